// File: doc/BRIEF.md
# Dual-Access Codec Control Register Bank

This block holds the 16-bit control words of an audio codec in a small register array that two agents share. The link side (the command decoder behind the serial codec link) presents a byte address, write data and read/write strobes; a second port serves the on-chip processor with the same kind of access. Both ports see one common store. A read on either port returns its word one clock after the strobe, with a valid flag.

The two ports see the two identification words at byte addresses 28h and 3Ch differently. Link-side reads replace bit 14 with the live level of a board strap pin and return bit 15 as zero. Processor reads see only the stored word, so the strap level never reaches the processor. Bit 12 of the power-down word at 26h forces the outgoing link bit clock and serial data-in lines low while it is set. A warm reset clears only that bit. A cold reset clears the whole array.

Top module: `codec_regbank`

## Requirements
- R1: A link-side write stores the word, and a later link-side read of any address other than 28h and 3Ch returns that word; link_rvalid is 1 in the cycle after each read strobe and 0 in the cycle after a cycle without one.
- R2: Both ports share one store: a word written on either port is returned by reads on the other port, and a processor read returns proc_rvalid one cycle after the strobe.
- R3: A link-side read of 28h or 3Ch returns, in bit 14, the strap_in level present in the strobe cycle, whatever is stored there.
- R4: A link-side read of 28h or 3Ch returns bit 15 as 0 and bits 13..0 as stored.
- R5: A processor read of 28h or 3Ch returns the stored 16-bit word unchanged, for either strap_in level.
- R6: While bit 12 of word 26h is 1, link_bclk_o and link_sdin_o are 0; while it is 0 they follow link_bclk_i and link_sdin_i. The change is visible in the cycle after the write edge.
- R7: A one-cycle warm_rst clears bit 12 of word 26h and leaves every other bit of the array unchanged. If a write to 26h happens in the same cycle, the other bits of that write are stored and bit 12 still ends at 0.
- R8: Cold reset (rst_n low) clears every word to 0, deasserts both rvalid flags and removes the output gating.
- R9: Address bit 0 is ignored on both ports: byte addresses 2k and 2k+1 select the same word.
- R10: When both ports write the same word in one cycle, the link-side data is stored and the processor data is dropped; writes to different words in one cycle both land.
- R11: A read of a word in the same cycle as a write to it returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| warm_rst | input | 1 | Warm reset pulse, synchronous |
| link_wr | input | 1 | Link-side write strobe |
| link_rd | input | 1 | Link-side read strobe |
| link_addr | input | 7 | Link-side byte address |
| link_wdata | input | 16 | Link-side write data |
| link_rdata | output | 16 | Link-side read data |
| link_rvalid | output | 1 | Link-side read data valid |
| proc_wr | input | 1 | Processor write strobe |
| proc_rd | input | 1 | Processor read strobe |
| proc_addr | input | 7 | Processor byte address |
| proc_wdata | input | 16 | Processor write data |
| proc_rdata | output | 16 | Processor read data |
| proc_rvalid | output | 1 | Processor read data valid |
| strap_in | input | 1 | Board strap pin level |
| link_bclk_i | input | 1 | Raw link bit clock |
| link_sdin_i | input | 1 | Raw serial data-in line |
| link_bclk_o | output | 1 | Gated link bit clock |
| link_sdin_o | output | 1 | Gated serial data-in line |

## Verification
Every cycle, the assertions check that the valid flags follow the strobes and that link-side ID reads carry the sampled strap level with bit 15 at zero. They also check that processor reads equal the raw stored word, that the link side wins a same-word collision, that warm reset leaves the power-down bit clear, and that the output lines stay low while that bit is set. Only the bench scenarios can show the round trip across the whole address space on both ports, the aliasing of odd addresses, read-before-write ordering, the rule that warm reset touches nothing else, and the all-zero state after a cold reset in mid-run.

// File: rtl/codec_regbank_pkg.sv
package codec_regbank_pkg;

    // Which view a read port presents of the shared store.
    typedef enum logic {
        VIEW_RAW  = 1'b0,   // stored word, untouched
        VIEW_LINK = 1'b1    // ID words carry the strap level and a zero bit
    } view_e;

endpackage

// File: rtl/codec_regbank_store.sv
module codec_regbank_store #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 6,
    parameter int PD_IDX = 19,
    parameter int PD_BIT = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           warm_rst,
    input  logic                           h_we,
    input  logic [IDX_W-1:0]               h_idx,
    input  logic [DATA_W-1:0]              h_wdata,
    input  logic                           p_we,
    input  logic [IDX_W-1:0]               p_idx,
    input  logic [DATA_W-1:0]              p_wdata,
    output logic [(1<<IDX_W)-1:0][DATA_W-1:0] mem_o,
    output logic                           pd_o
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            // processor first, link side last so it wins a collision
            if (p_we && (p_idx == IDX_W'(i))) st_d.mem[i] = p_wdata;
            if (h_we && (h_idx == IDX_W'(i))) st_d.mem[i] = h_wdata;
        end
        if (warm_rst) st_d.mem[PD_IDX][PD_BIT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_o = st_q.mem;
    assign pd_o  = st_q.mem[PD_IDX][PD_BIT];

    // R7: warm reset leaves the power-down bit clear
    a_r7_warm_clears_pd: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> !pd_o);

    // R10: link-side data survives a same-word collision
    a_r10_link_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && p_we && (h_idx == p_idx) && !warm_rst)
        |=> (mem_o[$past(h_idx)] == $past(h_wdata)));

endmodule

// File: rtl/codec_regbank_rdport.sv
module codec_regbank_rdport
    import codec_regbank_pkg::*;
#(
    parameter int    DATA_W    = 16,
    parameter int    IDX_W     = 6,
    parameter view_e VIEW      = VIEW_RAW,
    parameter int    ID_A_IDX  = 20,
    parameter int    ID_B_IDX  = 30,
    parameter int    STRAP_BIT = 14,
    parameter int    ZERO_BIT  = 15
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [(1<<IDX_W)-1:0][DATA_W-1:0] mem,
    input  logic                              strap,
    output logic [DATA_W-1:0]                 rdata,
    output logic                              rvalid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } resp_t;

    resp_t rs_d, rs_q;
    logic [DATA_W-1:0] raw_word;
    logic [DATA_W-1:0] view_word;
    logic              is_id;

    assign raw_word = mem[idx];
    assign is_id    = (idx == IDX_W'(ID_A_IDX)) || (idx == IDX_W'(ID_B_IDX));

    generate
        if (VIEW == VIEW_LINK) begin : g_link_view
            always_comb begin
                view_word = raw_word;
                if (is_id) begin
                    view_word[ZERO_BIT]  = 1'b0;
                    view_word[STRAP_BIT] = strap;
                end
            end

            // R3: strap level sampled with the strobe lands in the ID bit
            a_r3_strap_bit: assert property (@(posedge clk) disable iff (!rst_n)
                (rd && is_id) |=> (rdata[STRAP_BIT] == $past(strap)));

            // R4: top ID bit reads back as zero on the link side
            a_r4_zero_bit: assert property (@(posedge clk) disable iff (!rst_n)
                (rd && is_id) |=> !rdata[ZERO_BIT]);
        end else begin : g_raw_view
            logic unused_strap;
            assign unused_strap = strap;
            assign view_word    = raw_word;

            // R5: raw view never departs from the stored word
            a_r5_raw_word: assert property (@(posedge clk) disable iff (!rst_n)
                rd |=> (rdata == $past(mem[idx])));
        end
    endgenerate

    always_comb begin
        rs_d       = rs_q;
        rs_d.valid = rd;
        if (rd) rs_d.data = view_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rdata  = rs_q.data;
    assign rvalid = rs_q.valid;

    // R1: valid flag follows the strobe by one cycle
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);

endmodule

// File: rtl/codec_regbank_gate.sv
module codec_regbank_gate #(
    parameter int N_LINE = 2
) (
    input  logic              pd,
    input  logic [N_LINE-1:0] line_i,
    output logic [N_LINE-1:0] line_o
);
    generate
        for (genvar g = 0; g < N_LINE; g++) begin : g_line
            assign line_o[g] = line_i[g] & ~pd;
        end
    endgenerate
endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
    import codec_regbank_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 7,
    parameter int ID_A_ADDR = 'h28,
    parameter int ID_B_ADDR = 'h3C,
    parameter int PD_ADDR   = 'h26,
    parameter int PD_BIT    = 12,
    parameter int STRAP_BIT = 14,
    parameter int ZERO_BIT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              link_wr,
    input  logic              link_rd,
    input  logic [ADDR_W-1:0] link_addr,
    input  logic [DATA_W-1:0] link_wdata,
    output logic [DATA_W-1:0] link_rdata,
    output logic              link_rvalid,
    input  logic              proc_wr,
    input  logic              proc_rd,
    input  logic [ADDR_W-1:0] proc_addr,
    input  logic [DATA_W-1:0] proc_wdata,
    output logic [DATA_W-1:0] proc_rdata,
    output logic              proc_rvalid,
    input  logic              strap_in,
    input  logic              link_bclk_i,
    input  logic              link_sdin_i,
    output logic              link_bclk_o,
    output logic              link_sdin_o
);
    localparam int IDX_W    = ADDR_W - 1;
    localparam int DEPTH    = 1 << IDX_W;
    localparam int ID_A_IDX = ID_A_ADDR >> 1;
    localparam int ID_B_IDX = ID_B_ADDR >> 1;
    localparam int PD_IDX   = PD_ADDR >> 1;
    localparam int N_LINE   = 2;

    logic [IDX_W-1:0]              h_idx, p_idx;
    logic [DEPTH-1:0][DATA_W-1:0]  mem;
    logic                          pd;
    logic [N_LINE-1:0]             line_in, line_out;
    logic                          unused_addr_lsb;

    // word index drops the byte-address LSB
    assign h_idx           = link_addr[ADDR_W-1:1];
    assign p_idx           = proc_addr[ADDR_W-1:1];
    assign unused_addr_lsb = link_addr[0] ^ proc_addr[0];

    codec_regbank_store #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .PD_IDX (PD_IDX),
        .PD_BIT (PD_BIT)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .warm_rst (warm_rst),
        .h_we     (link_wr),
        .h_idx    (h_idx),
        .h_wdata  (link_wdata),
        .p_we     (proc_wr),
        .p_idx    (p_idx),
        .p_wdata  (proc_wdata),
        .mem_o    (mem),
        .pd_o     (pd)
    );

    codec_regbank_rdport #(
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W),
        .VIEW      (VIEW_LINK),
        .ID_A_IDX  (ID_A_IDX),
        .ID_B_IDX  (ID_B_IDX),
        .STRAP_BIT (STRAP_BIT),
        .ZERO_BIT  (ZERO_BIT)
    ) u_link_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (link_rd),
        .idx    (h_idx),
        .mem    (mem),
        .strap  (strap_in),
        .rdata  (link_rdata),
        .rvalid (link_rvalid)
    );

    codec_regbank_rdport #(
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W),
        .VIEW      (VIEW_RAW),
        .ID_A_IDX  (ID_A_IDX),
        .ID_B_IDX  (ID_B_IDX),
        .STRAP_BIT (STRAP_BIT),
        .ZERO_BIT  (ZERO_BIT)
    ) u_proc_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (proc_rd),
        .idx    (p_idx),
        .mem    (mem),
        .strap  (strap_in),
        .rdata  (proc_rdata),
        .rvalid (proc_rvalid)
    );

    assign line_in = {link_sdin_i, link_bclk_i};

    codec_regbank_gate #(
        .N_LINE (N_LINE)
    ) u_gate (
        .pd     (pd),
        .line_i (line_in),
        .line_o (line_out)
    );

    assign link_bclk_o = line_out[0];
    assign link_sdin_o = line_out[1];

    // R6: gated lines stay low while the stored power-down bit is set
    a_r6_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> (!link_bclk_o && !link_sdin_o));

endmodule

// File: tb/tb_codec_regbank.sv
module tb_codec_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        link_wr = 1'b0, link_rd = 1'b0;
    logic [6:0]  link_addr = '0;
    logic [15:0] link_wdata = '0;
    logic [15:0] link_rdata;
    logic        link_rvalid;
    logic        proc_wr = 1'b0, proc_rd = 1'b0;
    logic [6:0]  proc_addr = '0;
    logic [15:0] proc_wdata = '0;
    logic [15:0] proc_rdata;
    logic        proc_rvalid;
    logic        strap_in = 1'b0;
    logic        link_bclk_i = 1'b0, link_sdin_i = 1'b0;
    logic        link_bclk_o, link_sdin_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    codec_regbank dut (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .link_wr(link_wr), .link_rd(link_rd), .link_addr(link_addr),
        .link_wdata(link_wdata), .link_rdata(link_rdata), .link_rvalid(link_rvalid),
        .proc_wr(proc_wr), .proc_rd(proc_rd), .proc_addr(proc_addr),
        .proc_wdata(proc_wdata), .proc_rdata(proc_rdata), .proc_rvalid(proc_rvalid),
        .strap_in(strap_in), .link_bclk_i(link_bclk_i), .link_sdin_i(link_sdin_i),
        .link_bclk_o(link_bclk_o), .link_sdin_o(link_sdin_o)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int i, input logic [15:0] seed);
        return 16'(i * 16'h0409) ^ seed;
    endfunction

    function automatic logic [15:0] link_view(input int i, input logic [15:0] w,
                                              input logic s);
        logic [15:0] r = w;
        if (i == 'h14 || i == 'h1E) begin
            r[15] = 1'b0;
            r[14] = s;
        end
        return r;
    endfunction

    task automatic lwrite(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        link_wr = 1'b1; link_addr = a; link_wdata = d;
        @(negedge clk);
        link_wr = 1'b0;
    endtask

    task automatic pwrite(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        proc_wr = 1'b1; proc_addr = a; proc_wdata = d;
        @(negedge clk);
        proc_wr = 1'b0;
    endtask

    task automatic lread(input logic [6:0] a, output logic [15:0] d, output logic v);
        @(negedge clk);
        link_rd = 1'b1; link_addr = a;
        @(negedge clk);
        link_rd = 1'b0;
        d = link_rdata; v = link_rvalid;
    endtask

    task automatic pread(input logic [6:0] a, output logic [15:0] d, output logic v);
        @(negedge clk);
        proc_rd = 1'b1; proc_addr = a;
        @(negedge clk);
        proc_rd = 1'b0;
        d = proc_rdata; v = proc_rvalid;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %h expected %h", 16'h0, 16'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        logic        v;
        logic [15:0] seed_a = 16'hA5C3;
        logic [15:0] seed_b = 16'h3C96;

        repeat (3) @(negedge clk);
        // R8: reset state
        check(!link_rvalid && !proc_rvalid, "R8 rvalid low in reset",
              {14'h0, link_rvalid, proc_rvalid}, 16'h0);
        rst_n = 1'b1;
        link_bclk_i = 1'b1; link_sdin_i = 1'b1;
        @(negedge clk);
        check(link_bclk_o && link_sdin_o, "R8 no gating after reset",
              {14'h0, link_sdin_o, link_bclk_o}, 16'h3);
        lread(7'h26, d, v);
        check(d == 16'h0 && v, "R8 word 26h zero after reset", d, 16'h0);
        @(negedge clk);
        check(!link_rvalid, "R1 rvalid drops without strobe", {15'h0, link_rvalid}, 16'h0);

        // R1 R3 R4: link write sweep, link read sweep at both strap levels
        for (int i = 0; i < 64; i++) lwrite(7'(2 * i), pat(i, seed_a));
        for (int s = 0; s < 2; s++) begin
            strap_in = s[0];
            for (int i = 0; i < 64; i++) begin
                lread(7'(2 * i), d, v);
                check(d == link_view(i, pat(i, seed_a), s[0]) && v,
                      (i == 'h14 || i == 'h1E) ? "R3 R4 link ID view" : "R1 link round trip",
                      d, link_view(i, pat(i, seed_a), s[0]));
            end
        end

        // R2 R5: processor sees raw words, at both strap levels
        for (int s = 0; s < 2; s++) begin
            strap_in = s[0];
            for (int i = 0; i < 64; i++) begin
                pread(7'(2 * i), d, v);
                check(d == pat(i, seed_a) && v,
                      (i == 'h14 || i == 'h1E) ? "R5 proc raw ID" : "R2 proc sees link write",
                      d, pat(i, seed_a));
            end
        end

        // R6: power-down gating
        lwrite(7'h26, 16'h1000);
        check(!link_bclk_o && !link_sdin_o, "R6 gated after set",
              {14'h0, link_sdin_o, link_bclk_o}, 16'h0);
        link_bclk_i = 1'b0;
        @(negedge clk);
        link_bclk_i = 1'b1;
        @(negedge clk);
        check(!link_bclk_o && !link_sdin_o, "R6 stays gated",
              {14'h0, link_sdin_o, link_bclk_o}, 16'h0);
        pwrite(7'h26, 16'h0000);
        check(link_bclk_o && link_sdin_o, "R6 released after clear",
              {14'h0, link_sdin_o, link_bclk_o}, 16'h3);
        link_sdin_i = 1'b0;
        @(negedge clk);
        check(link_bclk_o && !link_sdin_o, "R6 follows inputs",
              {14'h0, link_sdin_o, link_bclk_o}, 16'h1);
        link_sdin_i = 1'b1;

        // R7: warm reset clears only bit 12 of 26h
        lwrite(7'h26, 16'hFFFF);
        @(negedge clk);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
        check(link_bclk_o && link_sdin_o, "R7 warm reset releases gating",
              {14'h0, link_sdin_o, link_bclk_o}, 16'h3);
        lread(7'h26, d, v);
        check(d == 16'hEFFF, "R7 other bits of 26h kept", d, 16'hEFFF);
        for (int i = 0; i < 64; i++) begin
            if (i != 'h13) begin
                pread(7'(2 * i), d, v);
                check(d == pat(i, seed_a), "R7 other words untouched", d, pat(i, seed_a));
            end
        end
        @(negedge clk);
        link_wr = 1'b1; link_addr = 7'h26; link_wdata = 16'hFFFF; warm_rst = 1'b1;
        @(negedge clk);
        link_wr = 1'b0; warm_rst = 1'b0;
        lread(7'h26, d, v);
        check(d == 16'hEFFF, "R7 warm reset beats same-cycle write", d, 16'hEFFF);

        // R9: odd addresses alias the even word
        lwrite(7'h41, 16'h5A5A);
        pread(7'h40, d, v);
        check(d == 16'h5A5A, "R9 odd link write hits even word", d, 16'h5A5A);
        pwrite(7'h40, 16'h1234);
        lread(7'h41, d, v);
        check(d == 16'h1234, "R9 odd link read", d, 16'h1234);

        // R10: collisions
        @(negedge clk);
        link_wr = 1'b1; link_addr = 7'h30; link_wdata = 16'hAAAA;
        proc_wr = 1'b1; proc_addr = 7'h31; proc_wdata = 16'h5555;
        @(negedge clk);
        link_wr = 1'b0; proc_wr = 1'b0;
        pread(7'h30, d, v);
        check(d == 16'hAAAA, "R10 link wins same word", d, 16'hAAAA);
        @(negedge clk);
        link_wr = 1'b1; link_addr = 7'h32; link_wdata = 16'h0F0F;
        proc_wr = 1'b1; proc_addr = 7'h34; proc_wdata = 16'hF0F0;
        @(negedge clk);
        link_wr = 1'b0; proc_wr = 1'b0;
        lread(7'h32, d, v);
        check(d == 16'h0F0F, "R10 link write to distinct word", d, 16'h0F0F);
        lread(7'h34, d, v);
        check(d == 16'hF0F0, "R10 proc write to distinct word", d, 16'hF0F0);

        // R11: read during write returns the old value
        @(negedge clk);
        link_wr = 1'b1; link_addr = 7'h50; link_wdata = 16'hBEEF;
        proc_rd = 1'b1; proc_addr = 7'h50;
        @(negedge clk);
        link_wr = 1'b0; proc_rd = 1'b0;
        check(proc_rdata == pat('h28, seed_a) && proc_rvalid, "R11 old value on collision",
              proc_rdata, pat('h28, seed_a));
        pread(7'h50, d, v);
        check(d == 16'hBEEF, "R11 new value afterwards", d, 16'hBEEF);

        // R2: processor write sweep, link reads back
        strap_in = 1'b1;
        for (int i = 0; i < 64; i++) pwrite(7'(2 * i), pat(i, seed_b));
        for (int i = 0; i < 64; i++) begin
            lread(7'(2 * i), d, v);
            check(d == link_view(i, pat(i, seed_b), 1'b1) && v, "R2 link sees proc write",
                  d, link_view(i, pat(i, seed_b), 1'b1));
        end

        // R8: cold reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(link_bclk_o && link_sdin_o, "R8 gating cleared by cold reset",
              {14'h0, link_sdin_o, link_bclk_o}, 16'h3);
        strap_in = 1'b0;
        for (int i = 0; i < 64; i++) begin
            pread(7'(2 * i), d, v);
            check(d == 16'h0, "R8 word cleared", d, 16'h0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule